// File: doc/BRIEF.md
# Binary32 Result Packer with Gradual Underflow

This block takes an arithmetic result that is still in a wide internal form and produces a binary32 word. The internal form has a sign, a signed exponent that is wider than the storage exponent, and a significand with an explicit leading one plus a guard bit and a sticky bit. Because the exponent is wide, results far below the normal range arrive still normalized. The packer must then place them correctly.

When the exponent lies below the smallest normal exponent, the first stage moves the significand right into subnormal position. Every bit pushed past the guard position is folded into sticky. The second stage applies round-to-nearest-even once, at the final bit position. It then selects a normal, subnormal, zero or infinity encoding and raises the overflow, underflow and inexact flags.

An optional flush-to-zero input replaces every would-be subnormal with a signed zero. Every result, on every path, emerges exactly two clock cycles after it is accepted. A new operand may be accepted on every cycle.

Top module: `fp_result_packer`

## Requirements
- R1: An operand with unbiased exponent from -126 to 127 and significand bit 23 set is output with the sign in bit 31, the exponent plus 127 in bits 30:23 and the 23 fraction bits in bits 22:0, after rounding.
- R2: Rounding is to nearest, ties to even. The kept value is incremented when the guard bit is 1 and either the sticky bit or the kept least significant bit is 1. A carry out of the fraction raises the exponent field by one and clears the fraction.
- R3: For an exponent e below -126, the 24-bit significand is shifted right by (-126 - e) and the exponent field is 0. Shifted-out bits are ORed into sticky. A shift of 25 or more leaves only sticky information, so the kept bits and the guard bit are zero.
- R4: Rounding is applied only once, after the shift, using the guard and sticky bits at the subnormal position. No rounding is done at the 24-bit position before the shift.
- R5: A subnormal that rounds up to 2^-126 is output with exponent field 1 and fraction 0.
- R6: If the exponent field after rounding would reach 255 or more, the output is an infinity with the operand sign (exponent field 255, fraction 0), and the overflow and inexact flags are set.
- R7: With flush-to-zero on, a nonzero operand whose exponent is below -126 is output as a zero with its sign, and the underflow and inexact flags are set. This also applies when rounding would have reached 2^-126. Operands in the normal range are unaffected by the mode.
- R8: Inexact is set when the guard or sticky bit after the shift is nonzero, and on overflow or flush. Underflow is set when the exponent is below -126 and the result is inexact. An exact subnormal raises no flag.
- R9: A significand of all zeros gives a zero with the operand sign, with no flags, regardless of exponent and mode.
- R10: Each accepted operand produces its result and flags with outValid exactly two cycles later, with back-to-back operands allowed. Between results, the outputs hold their last values.
- R11: After reset, outValid, the output word and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand present this cycle |
| inSign | input | 1 | Operand sign |
| inExp | input | 10 | Signed unbiased operand exponent |
| inSig | input | 24 | Significand with explicit leading one, or all zeros |
| inGuard | input | 1 | First bit below the significand |
| inSticky | input | 1 | OR of all lower bits |
| ftzEn | input | 1 | Flush-to-zero mode |
| outValid | output | 1 | Packed result present |
| outBits | output | 32 | Packed binary32 word |
| flagOvf | output | 1 | Overflow flag |
| flagUnf | output | 1 | Underflow flag |
| flagInx | output | 1 | Inexact flag |

## Verification
The assertions assume the significand arrives either with bit 23 set or as all zeros. They also assume the exponent stays well inside the signed 10-bit range, so that the bias and shift arithmetic cannot wrap. Under those assumptions, the assertions claim that a value below the normal range never keeps its leading one after the shift, that flushes and overflows always encode as they should, and that underflow never appears without inexact. The directed stimulus only uses normalized or zero significands, with exponents between -200 and 300. It targets the boundaries around -126, -149, -150 and 127, plus ties at both the normal and the subnormal rounding position.

// File: rtl/fp_pack_pkg.sv
package fp_pack_pkg;
  localparam int MAN_W     = 23;
  localparam int EXP_STORE = 8;
  localparam int IN_EXP_W  = 10;

  localparam int SIG_W         = MAN_W + 1;
  localparam int EXT_W         = SIG_W + 2;
  localparam int BIAS          = (1 << (EXP_STORE - 1)) - 1;
  localparam int EMIN          = 1 - BIAS;
  localparam int EXP_FIELD_MAX = (1 << EXP_STORE) - 1;
  localparam int OUT_W         = 1 + EXP_STORE + MAN_W;
  localparam int WEXP_W        = IN_EXP_W + 2;
  localparam int SH_W          = $clog2(EXT_W + 1);

  typedef struct packed {
    logic ldAlign;
    logic ldRound;
  } stageStrobes_t;

  typedef struct packed {
    logic                     sign;
    logic                     isZero;
    logic                     tiny;
    logic                     flush;
    logic signed [WEXP_W-1:0] biasedExp;
    logic [SIG_W-1:0]         sig;
    logic                     guard;
    logic                     sticky;
  } alignStage_t;
endpackage

// File: rtl/fp_denorm_shift.sv
module fp_denorm_shift
  import fp_pack_pkg::*;
(
  input  logic [EXT_W-1:0] extIn,
  input  logic [SH_W-1:0]  shAmt,
  output logic [SIG_W-1:0] sigOut,
  output logic             guardOut,
  output logic             stickyOut
);
  logic [EXT_W-1:0] shifted;
  logic [EXT_W-1:0] lostMask;

  assign shifted = extIn >> shAmt;

  // A bit is lost when its position falls below the shift amount.
  for (genvar i = 0; i < EXT_W; i++) begin : gLost
    assign lostMask[i] = extIn[i] & (SH_W'(i) < shAmt);
  end

  assign sigOut    = shifted[EXT_W-1:2];
  assign guardOut  = shifted[1];
  assign stickyOut = shifted[0] | (|lostMask);
endmodule

// File: rtl/fp_pack_ctrl.sv
module fp_pack_ctrl
  import fp_pack_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output stageStrobes_t strobes,
  output logic          outValid
);
  logic       alignValid;
  logic       roundValid;
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alignValid <= 1'b0;
      roundValid <= 1'b0;
      warm       <= 2'd0;
    end else begin
      alignValid <= inValid;
      roundValid <= alignValid;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  assign strobes.ldAlign = inValid;
  assign strobes.ldRound = alignValid;
  assign outValid        = roundValid;

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (warm >= 2'd2) |-> (outValid == $past(inValid, 2))); // R10
endmodule

// File: rtl/fp_pack_datapath.sv
module fp_pack_datapath
  import fp_pack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stageStrobes_t       strobes,
  input  logic                inSign,
  input  logic [IN_EXP_W-1:0] inExp,
  input  logic [SIG_W-1:0]    inSig,
  input  logic                inGuard,
  input  logic                inSticky,
  input  logic                ftzEn,
  output logic [OUT_W-1:0]    outBits,
  output logic                flagOvf,
  output logic                flagUnf,
  output logic                flagInx
);
  localparam logic signed [WEXP_W-1:0] EMIN_W      = WEXP_W'(EMIN);
  localparam logic signed [WEXP_W-1:0] BIAS_W      = WEXP_W'(BIAS);
  localparam logic signed [WEXP_W-1:0] SHIFT_CAP   = WEXP_W'(EXT_W);
  localparam logic signed [WEXP_W-1:0] FIELD_MAX_W = WEXP_W'(EXP_FIELD_MAX);

  // Stage 1: align into subnormal position.
  logic signed [WEXP_W-1:0] expW;
  logic signed [WEXP_W-1:0] shiftRaw;
  logic                     tinyD;
  logic [SH_W-1:0]          shAmt;
  logic [SIG_W-1:0]         shSig;
  logic                     shGuard;
  logic                     shSticky;
  alignStage_t              alignD;
  alignStage_t              alignQ;

  assign expW     = {{(WEXP_W - IN_EXP_W){inExp[IN_EXP_W-1]}}, inExp};
  assign tinyD    = expW < EMIN_W;
  assign shiftRaw = EMIN_W - expW;

  always_comb begin
    if (!tinyD)                  shAmt = '0;
    else if (shiftRaw >= SHIFT_CAP) shAmt = SH_W'(EXT_W);
    else                         shAmt = shiftRaw[SH_W-1:0];
  end

  fp_denorm_shift uShift (
    .extIn    ({inSig, inGuard, inSticky}),
    .shAmt    (shAmt),
    .sigOut   (shSig),
    .guardOut (shGuard),
    .stickyOut(shSticky)
  );

  always_comb begin
    alignD.sign      = inSign;
    alignD.isZero    = ~inSig[SIG_W-1];
    alignD.tiny      = tinyD;
    alignD.flush     = ftzEn & tinyD & inSig[SIG_W-1];
    alignD.biasedExp = tinyD ? '0 : expW + BIAS_W;
    alignD.sig       = shSig;
    alignD.guard     = shGuard;
    alignD.sticky    = shSticky;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                alignQ <= '0;
    else if (strobes.ldAlign) alignQ <= alignD;
  end

  AST_TINY_SHIFTED: assert property (@(posedge clk) disable iff (!rstN)
    alignQ.tiny |-> !alignQ.sig[SIG_W-1]); // R3

  // Stage 2: round once at the final position, then encode.
  logic                     roundUp;
  logic                     lostBits;
  logic [SIG_W:0]           sum;
  logic signed [WEXP_W-1:0] expField;
  logic                     ovfD;
  logic [OUT_W-1:0]         bitsD;
  logic                     ovfFlagD;
  logic                     unfFlagD;
  logic                     inxFlagD;

  assign roundUp  = alignQ.guard & (alignQ.sticky | alignQ.sig[0]);
  assign lostBits = alignQ.guard | alignQ.sticky;
  assign sum      = {1'b0, alignQ.sig} + (SIG_W + 1)'(roundUp);
  assign expField = alignQ.tiny ? WEXP_W'(sum[SIG_W-1])
                                : alignQ.biasedExp + WEXP_W'(sum[SIG_W]);
  assign ovfD     = !alignQ.tiny && (expField >= FIELD_MAX_W);

  always_comb begin
    bitsD    = {alignQ.sign, expField[EXP_STORE-1:0], sum[MAN_W-1:0]};
    ovfFlagD = 1'b0;
    unfFlagD = alignQ.tiny & lostBits;
    inxFlagD = lostBits;
    if (alignQ.isZero) begin
      bitsD    = {alignQ.sign, {(OUT_W-1){1'b0}}};
      unfFlagD = 1'b0;
      inxFlagD = 1'b0;
    end else if (alignQ.flush) begin
      bitsD    = {alignQ.sign, {(OUT_W-1){1'b0}}};
      unfFlagD = 1'b1;
      inxFlagD = 1'b1;
    end else if (ovfD) begin
      bitsD    = {alignQ.sign, {EXP_STORE{1'b1}}, {MAN_W{1'b0}}};
      ovfFlagD = 1'b1;
      inxFlagD = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outBits <= '0;
      flagOvf <= 1'b0;
      flagUnf <= 1'b0;
      flagInx <= 1'b0;
    end else if (strobes.ldRound) begin
      outBits <= bitsD;
      flagOvf <= ovfFlagD;
      flagUnf <= unfFlagD;
      flagInx <= inxFlagD;
    end
  end

  AST_OVF_INF: assert property (@(posedge clk) disable iff (!rstN)
    flagOvf |-> (outBits[OUT_W-2:0] == {{EXP_STORE{1'b1}}, {MAN_W{1'b0}}}) && flagInx); // R6

  AST_UNF_HAS_INX: assert property (@(posedge clk) disable iff (!rstN)
    flagUnf |-> flagInx); // R8

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.ldRound && alignQ.flush) |=> (outBits[OUT_W-2:0] == '0) && flagUnf && flagInx); // R7
endmodule

// File: rtl/fp_result_packer.sv
module fp_result_packer
  import fp_pack_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic                inSign,
  input  logic [IN_EXP_W-1:0] inExp,
  input  logic [SIG_W-1:0]    inSig,
  input  logic                inGuard,
  input  logic                inSticky,
  input  logic                ftzEn,
  output logic                outValid,
  output logic [OUT_W-1:0]    outBits,
  output logic                flagOvf,
  output logic                flagUnf,
  output logic                flagInx
);
  stageStrobes_t strobes;

  fp_pack_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  fp_pack_datapath uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inSign  (inSign),
    .inExp   (inExp),
    .inSig   (inSig),
    .inGuard (inGuard),
    .inSticky(inSticky),
    .ftzEn   (ftzEn),
    .outBits (outBits),
    .flagOvf (flagOvf),
    .flagUnf (flagUnf),
    .flagInx (flagInx)
  );
endmodule

// File: tb/tb_fp_result_packer.sv
`timescale 1ns/1ps
module tb_fp_result_packer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inSign = 1'b0;
  logic [9:0]  inExp = '0;
  logic [23:0] inSig = '0;
  logic        inGuard = 1'b0;
  logic        inSticky = 1'b0;
  logic        ftzEn = 1'b0;
  logic        outValid;
  logic [31:0] outBits;
  logic        flagOvf, flagUnf, flagInx;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  fp_result_packer dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSign(inSign), .inExp(inExp),
    .inSig(inSig), .inGuard(inGuard), .inSticky(inSticky), .ftzEn(ftzEn),
    .outValid(outValid), .outBits(outBits), .flagOvf(flagOvf),
    .flagUnf(flagUnf), .flagInx(flagInx)
  );

  // flags expected as {ovf, unf, inx}
  task automatic checkOut(string req, logic expValid, logic [31:0] expBits, logic [2:0] expFlags);
    logic [2:0] gotFlags;
    gotFlags = {flagOvf, flagUnf, flagInx};
    checks++;
    if (outValid !== expValid || outBits !== expBits || gotFlags !== expFlags) begin
      failures++;
      $display("FAIL %s: got valid=%0b bits=%08h flags=%03b, expected valid=%0b bits=%08h flags=%03b",
               req, outValid, outBits, gotFlags, expValid, expBits, expFlags);
    end
  endtask

  task automatic drive(logic s, int e, logic [23:0] sig, logic g, logic st, logic ftz);
    inValid  = 1'b1;
    inSign   = s;
    inExp    = 10'(e);
    inSig    = sig;
    inGuard  = g;
    inSticky = st;
    ftzEn    = ftz;
  endtask

  task automatic runOne(string req, logic s, int e, logic [23:0] sig, logic g, logic st,
                        logic ftz, logic [31:0] expBits, logic [2:0] expFlags);
    @(negedge clk);
    drive(s, e, sig, g, st, ftz);
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    checkOut(req, 1'b1, expBits, expFlags);
  endtask

  task automatic testReset();
    @(negedge clk);
    checkOut("R11 reset state", 1'b0, 32'h0, 3'b000);
  endtask

  task automatic testNormal();
    runOne("R1 exact one",        0, 0,   24'h800000, 0, 0, 0, 32'h3F800000, 3'b000);
    runOne("R1 negative normal",  1, 3,   24'hC00000, 0, 0, 0, 32'hC1400000, 3'b000);
    runOne("R1 min normal",       0, -126, 24'h800000, 0, 0, 0, 32'h00800000, 3'b000);
    runOne("R1 max normal",       0, 127, 24'hFFFFFF, 0, 0, 0, 32'h7F7FFFFF, 3'b000);
  endtask

  task automatic testRounding();
    runOne("R2 tie to even stays", 0, 0, 24'h800000, 1, 0, 0, 32'h3F800000, 3'b001);
    runOne("R2 tie odd rounds up", 0, 0, 24'h800001, 1, 0, 0, 32'h3F800002, 3'b001);
    runOne("R2 sticky only down",  0, 0, 24'h800001, 0, 1, 0, 32'h3F800001, 3'b001);
    runOne("R2 carry to exponent", 0, 0, 24'hFFFFFF, 1, 0, 0, 32'h40000000, 3'b001);
  endtask

  task automatic testSubnormal();
    runOne("R3 shift 1 exact",     0, -127, 24'h800000, 0, 0, 0, 32'h00400000, 3'b000);
    runOne("R3 smallest exact",    0, -149, 24'h800000, 0, 0, 0, 32'h00000001, 3'b000);
    runOne("R3 shift 24 tie even", 0, -150, 24'h800000, 0, 0, 0, 32'h00000000, 3'b011);
    runOne("R3 shift 24 above tie",0, -150, 24'h800001, 0, 0, 0, 32'h00000001, 3'b011);
    runOne("R3 shift 25 sticky",   0, -151, 24'hFFFFFF, 0, 0, 0, 32'h00000000, 3'b011);
    runOne("R3 huge shift",        1, -200, 24'h800000, 0, 0, 0, 32'h80000000, 3'b011);
    runOne("R4 single rounding",   0, -127, 24'h800002, 1, 1, 0, 32'h00400001, 3'b011);
    runOne("R5 round to min normal",0,-127, 24'hFFFFFF, 0, 0, 0, 32'h00800000, 3'b011);
    runOne("R8 sticky-only subnormal inexact", 0, -127, 24'h800000, 0, 1, 0, 32'h00400000, 3'b011);
  endtask

  task automatic testOverflow();
    runOne("R6 exponent 128",      0, 128, 24'h800000, 0, 0, 0, 32'h7F800000, 3'b101);
    runOne("R6 rounding overflow", 1, 127, 24'hFFFFFF, 1, 1, 0, 32'hFF800000, 3'b101);
    runOne("R6 far overflow",      0, 300, 24'hA00000, 0, 0, 0, 32'h7F800000, 3'b101);
  endtask

  task automatic testFlush();
    runOne("R7 flush negative",    1, -130, 24'h800000, 0, 0, 1, 32'h80000000, 3'b011);
    runOne("R7 flush exact",       0, -127, 24'h800000, 0, 0, 1, 32'h00000000, 3'b011);
    runOne("R7 flush beats round", 0, -127, 24'hFFFFFF, 0, 0, 1, 32'h00000000, 3'b011);
    runOne("R7 normal unaffected", 0, -126, 24'h800000, 0, 0, 1, 32'h00800000, 3'b000);
  endtask

  task automatic testZero();
    runOne("R9 negative zero",     1, 5,    24'h000000, 0, 0, 0, 32'h80000000, 3'b000);
    runOne("R9 zero with flush",   0, -200, 24'h000000, 0, 0, 1, 32'h00000000, 3'b000);
  endtask

  task automatic testStream();
    logic [31:0] expB [3];
    logic [2:0]  expF [3];
    expB[0] = 32'h3F800000; expF[0] = 3'b000;
    expB[1] = 32'h00000001; expF[1] = 3'b011;
    expB[2] = 32'hFF800000; expF[2] = 3'b101;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      if (c >= 2 && c < 5) checkOut("R10 back-to-back", 1'b1, expB[c-2], expF[c-2]);
      if (c == 5) checkOut("R10 hold after stream", 1'b0, expB[2], expF[2]);
      case (c)
        0: drive(0, 0,    24'h800000, 0, 0, 0);
        1: drive(0, -150, 24'h800001, 0, 0, 0);
        2: drive(1, 129,  24'h800000, 0, 0, 0);
        default: inValid = 1'b0;
      endcase
    end
    repeat (3) @(negedge clk);
    checkOut("R10 outputs hold when idle", 1'b0, expB[2], expF[2]);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testNormal();
    testRounding();
    testSubnormal();
    testOverflow();
    testFlush();
    testZero();
    testStream();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule